// File: doc/BRIEF.md
# Counter and Pseudo-Random Sequence Link Tester

This block is a paired pattern source and pattern checker for exercising a data link. The source side drives a stream of 32-bit words that is either an incrementing counter or a pseudo-random sequence. Each sequence starts from a programmable start word, and the counter wraps at a programmable modulus. The checker side takes a stream of words from the far end of the link. It seeds its reference from the first word it accepts and then judges every later word against that reference.

For counter data the checker does not insist on a single increment. A word is accepted if it equals the previous word plus any one of four programmable step values. This lets a link that drops or repeats words in known amounts still pass. The checker keeps a word count, an error count, the most recently received word and a result code. The result code tells apart four outcomes: a test that never ran, a test that timed out without seeing any data, a test that saw data and found it wrong, and a test that passed.

Both streams use valid/ready handshakes. The source holds its word steady while the sink holds ready low, and advances by one word per accepted transfer. The checker never applies back-pressure, so its ready output is always high. Control and status go through a small register port of sixteen 32-bit words. Writes take effect at a clock edge, and reads return data combinationally.

Top module: `seqtest_top`

## Requirements
- R1: Register map, indexed by `reg_addr`. 0 = start word. 1 = counter modulus (shared by source and checker). 2 = source control. 3 = source transfer count (read-only). 8..11 = checker steps 0..3. 12 = checker control. 13 = checker word count (read-only). 14 = checker status (read-only). 15 = last received word (read-only). After reset all counts read 0 and the status result field reads 1.
- R2: Source control bit 0 enables the source and bit 1 selects counter data. Value 1 gives pseudo-random data, 3 gives counter data, and 0 or 2 disable it. `tx_valid` equals the enable bit.
- R3: In counter mode the first word after a control write is the start word. Each accepted transfer then adds 1. With a modulus M other than 0 the value returns to 0 on reaching M. M = 0 means wrap at 2^32.
- R4: In pseudo-random mode the first word is the start word. Each accepted transfer then replaces word s with {s[30:0], s[31]^s[21]^s[1]^s[0]}, which is polynomial x^32+x^22+x^2+x+1.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds steady. The transfer count rises by one per accepted transfer and is cleared by any source control write.
- R6: Checker control bit 0 enables the checker, and bit 1 selects counter checking (1 = pseudo-random, 3 = counter). A write with bit 0 set clears the counts, the seed and the last word, and sets the result to 1. Input words offered while the checker is disabled change nothing. `rx_ready` is constantly 1.
- R7: The first accepted word only seeds the checker. In pseudo-random mode every later word must equal the R4 successor of the previous received word.
- R8: In counter mode a later word passes if it equals (previous + step k) for any k in 0..3. When modulus M is not 0, M is subtracted once from a sum of M or more. This assumes the previous word and the steps are at most M. With M = 0 the sum wraps at 2^32.
- R9: Status bits [31:8] count the failing words. The reference always follows the received word, so one corrupt word inside a pseudo-random stream counts two errors. Address 15 holds the last accepted word.
- R10: The result code is status bits [2:0]. 0 = data seen with no error, 1 = not run, 2 = timeout, 3 = data seen with at least one error, 4 = illegal internal state. Code 3 stays until the next enabling write.
- R11: Checker control bits [31:8] give a cycle limit. If that many cycles pass after enabling with no word accepted, the result becomes 2. It stays 2 even if words arrive later, and those words are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Source word valid |
| tx_ready | input | 1 | Sink ready for source word |
| tx_data | output | 32 | Source word |
| rx_valid | input | 1 | Received word valid |
| rx_ready | output | 1 | Checker ready, always 1 |
| rx_data | input | 32 | Received word |

## Verification
The source is walked through a table of settings:
- a counter with a small modulus, which shows the wrap to zero;
- a counter near 2^32 with modulus 0, which shows the natural wrap;
- two pseudo-random seeds, which separate the feedback taps from a plain shift.

The checker is fed three kinds of stream:
- a clean pseudo-random stream, then the same stream with one corrupted word, which separates resynchronising on the received word from holding a private reference;
- a counter stream that uses every step value, including a zero step and a step that crosses the modulus;
- a silent input, which separates timeout from not-run.

Words offered while the checker is disabled, and a stalled source sink, show that nothing moves when it must not.

// File: rtl/seqtest_pkg.sv
package seqtest_pkg;
  localparam int WORD_W  = 32;
  localparam int NSTEPS  = 4;
  localparam int ERR_W   = WORD_W - 8;
  localparam int TIMER_W = WORD_W - 8;
  localparam int ADDR_W  = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_NONE    = 3'd1,
    RES_TIMEOUT = 3'd2,
    RES_ERROR   = 3'd3,
    RES_ILLEGAL = 3'd4
  } result_t;

  localparam logic [ADDR_W-1:0] A_INIT    = 4'd0;
  localparam logic [ADDR_W-1:0] A_MOD     = 4'd1;
  localparam logic [ADDR_W-1:0] A_TXCTL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXCNT   = 4'd3;
  localparam logic [ADDR_W-1:0] A_STEP0   = 4'd8;
  localparam logic [ADDR_W-1:0] A_RXCTL   = 4'd12;
  localparam logic [ADDR_W-1:0] A_RXWORDS = 4'd13;
  localparam logic [ADDR_W-1:0] A_RXSTAT  = 4'd14;
  localparam logic [ADDR_W-1:0] A_RXLAST  = 4'd15;

  // Fibonacci form of x^32 + x^22 + x^2 + x + 1
  function automatic word_t prbs_next(word_t s);
    return {s[WORD_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // a + b reduced once by m; m == 0 means natural 2^WORD_W wrap
  function automatic word_t mod_add(word_t a, word_t b, word_t m);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (m != '0 && s >= {1'b0, m})
      s = s - {1'b0, m};
    return s[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/seqtest_regs.sv
module seqtest_regs
  import seqtest_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  word_t                    wdata,
  output word_t                    rdata,
  output word_t                    init_o,
  output word_t                    mod_o,
  output logic                     tx_en_o,
  output logic                     tx_cnt_mode_o,
  output logic                     tx_start_o,
  output logic [NSTEPS-1:0][WORD_W-1:0] steps_o,
  output logic                     rx_en_o,
  output logic                     rx_cnt_mode_o,
  output logic [TIMER_W-1:0]       rx_limit_o,
  output logic                     rx_start_o,
  input  word_t                    tx_count_i,
  input  word_t                    rx_words_i,
  input  logic [ERR_W-1:0]         rx_errs_i,
  input  word_t                    rx_last_i,
  input  result_t                  rx_result_i
);
  localparam int STEP_IDX_W = $clog2(NSTEPS);

  word_t init_q, mod_q, txctl_q, rxctl_q;
  logic [NSTEPS-1:0][WORD_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      mod_q   <= '0;
      txctl_q <= '0;
      rxctl_q <= '0;
      for (int k = 0; k < NSTEPS; k++)
        step_q[k] <= (k == 0) ? word_t'(1) : '0;
    end else if (we) begin
      case (addr)
        A_INIT:  init_q  <= wdata;
        A_MOD:   mod_q   <= wdata;
        A_TXCTL: txctl_q <= wdata;
        A_RXCTL: rxctl_q <= wdata;
        default: begin
          if (addr[ADDR_W-1:STEP_IDX_W] == A_STEP0[ADDR_W-1:STEP_IDX_W])
            step_q[addr[STEP_IDX_W-1:0]] <= wdata;
        end
      endcase
    end
  end

  assign tx_start_o = we && (addr == A_TXCTL);
  assign rx_start_o = we && (addr == A_RXCTL) && wdata[0];

  assign init_o        = init_q;
  assign mod_o         = mod_q;
  assign tx_en_o       = txctl_q[0];
  assign tx_cnt_mode_o = txctl_q[1];
  assign steps_o       = step_q;
  assign rx_en_o       = rxctl_q[0];
  assign rx_cnt_mode_o = rxctl_q[1];
  assign rx_limit_o    = rxctl_q[WORD_W-1:WORD_W-TIMER_W];

  always_comb begin
    rdata = '0;
    case (addr)
      A_INIT:    rdata = init_q;
      A_MOD:     rdata = mod_q;
      A_TXCTL:   rdata = txctl_q;
      A_TXCNT:   rdata = tx_count_i;
      A_RXCTL:   rdata = rxctl_q;
      A_RXWORDS: rdata = rx_words_i;
      A_RXSTAT:  rdata = {rx_errs_i, {(WORD_W-ERR_W-3){1'b0}}, rx_result_i};
      A_RXLAST:  rdata = rx_last_i;
      default: begin
        if (addr[ADDR_W-1:STEP_IDX_W] == A_STEP0[ADDR_W-1:STEP_IDX_W])
          rdata = step_q[addr[STEP_IDX_W-1:0]];
      end
    endcase
  end
endmodule

// File: rtl/seqtest_tx.sv
module seqtest_tx
  import seqtest_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  en_i,
  input  logic  cnt_mode_i,
  input  word_t init_i,
  input  word_t mod_i,
  input  logic  ready_i,
  output logic  valid_o,
  output word_t data_o,
  output word_t count_o
);
  word_t cur_q, cnt_q, nxt;

  always_comb begin
    if (cnt_mode_i) nxt = mod_add(cur_q, word_t'(1), mod_i);
    else            nxt = prbs_next(cur_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cur_q <= init_i;
      cnt_q <= '0;
    end else if (en_i && ready_i) begin
      cur_q <= nxt;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = en_i;
  assign data_o  = cur_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/seqtest_rx.sv
module seqtest_rx
  import seqtest_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     en_i,
  input  logic                     cnt_mode_i,
  input  logic [TIMER_W-1:0]       limit_i,
  input  logic [NSTEPS-1:0][WORD_W-1:0] steps_i,
  input  word_t                    mod_i,
  input  logic                     valid_i,
  input  word_t                    data_i,
  output word_t                    words_o,
  output logic [ERR_W-1:0]         errs_o,
  output word_t                    last_o,
  output result_t                  result_o
);
  word_t              prev_q, words_q;
  logic               seen_q;
  logic [ERR_W-1:0]   errs_q;
  logic [TIMER_W-1:0] timer_q;
  result_t            res_q, res_d;
  logic [NSTEPS-1:0]  step_hit;
  logic               word_ok, take, bad;

  for (genvar k = 0; k < NSTEPS; k++) begin : g_step
    assign step_hit[k] = (mod_add(prev_q, steps_i[k], mod_i) == data_i);
  end

  assign word_ok = cnt_mode_i ? (|step_hit) : (prbs_next(prev_q) == data_i);
  assign take    = valid_i && en_i;
  assign bad     = take && seen_q && !word_ok;

  always_comb begin
    res_d = res_q;
    case (res_q)
      RES_NONE: begin
        if (take)                    res_d = RES_OK;
        else if (en_i && timer_q >= limit_i) res_d = RES_TIMEOUT;
      end
      RES_OK:      if (bad) res_d = RES_ERROR;
      RES_ERROR:   res_d = RES_ERROR;
      RES_TIMEOUT: res_d = RES_TIMEOUT;
      default:     res_d = RES_ILLEGAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      words_q <= '0;
      seen_q  <= 1'b0;
      errs_q  <= '0;
      timer_q <= '0;
      res_q   <= RES_NONE;
    end else if (start_i) begin
      prev_q  <= '0;
      words_q <= '0;
      seen_q  <= 1'b0;
      errs_q  <= '0;
      timer_q <= '0;
      res_q   <= RES_NONE;
    end else begin
      res_q <= res_d;
      if (en_i && res_q == RES_NONE && timer_q != '1)
        timer_q <= timer_q + 1'b1;
      if (take) begin
        prev_q  <= data_i;
        seen_q  <= 1'b1;
        words_q <= words_q + 1'b1;
        if (bad && errs_q != '1)
          errs_q <= errs_q + 1'b1;
      end
    end
  end

  assign words_o  = words_q;
  assign errs_o   = errs_q;
  assign last_o   = prev_q;
  assign result_o = res_q;
endmodule

// File: rtl/seqtest_top.sv
module seqtest_top
  import seqtest_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_data
);
  word_t init_w, mod_w, tx_cnt_w, rx_words_w, rx_last_w;
  logic  tx_en_w, tx_mode_w, tx_start_w;
  logic  rx_en_w, rx_mode_w, rx_start_w;
  logic [TIMER_W-1:0] rx_limit_w;
  logic [ERR_W-1:0]   rx_errs_w;
  logic [NSTEPS-1:0][WORD_W-1:0] steps_w;
  result_t rx_result_w;

  seqtest_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .init_o(init_w), .mod_o(mod_w),
    .tx_en_o(tx_en_w), .tx_cnt_mode_o(tx_mode_w), .tx_start_o(tx_start_w),
    .steps_o(steps_w), .rx_en_o(rx_en_w), .rx_cnt_mode_o(rx_mode_w),
    .rx_limit_o(rx_limit_w), .rx_start_o(rx_start_w),
    .tx_count_i(tx_cnt_w), .rx_words_i(rx_words_w), .rx_errs_i(rx_errs_w),
    .rx_last_i(rx_last_w), .rx_result_i(rx_result_w)
  );

  seqtest_tx u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start_w), .en_i(tx_en_w),
    .cnt_mode_i(tx_mode_w), .init_i(init_w), .mod_i(mod_w),
    .ready_i(tx_ready), .valid_o(tx_valid), .data_o(tx_data),
    .count_o(tx_cnt_w)
  );

  seqtest_rx u_rx (
    .clk(clk), .rst_n(rst_n), .start_i(rx_start_w), .en_i(rx_en_w),
    .cnt_mode_i(rx_mode_w), .limit_i(rx_limit_w), .steps_i(steps_w),
    .mod_i(mod_w), .valid_i(rx_valid), .data_i(rx_data),
    .words_o(rx_words_w), .errs_o(rx_errs_w), .last_o(rx_last_w),
    .result_o(rx_result_w)
  );

  assign rx_ready = 1'b1;
endmodule

// File: rtl/seqtest_chk.sv
module seqtest_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic [31:0] tx_cnt,
  input logic        rx_en,
  input logic [31:0] rx_words,
  input logic [2:0]  rx_result
);
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !reg_we) |=> $stable(tx_data));

  p_tx_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !reg_we) |=> (tx_cnt == $past(tx_cnt) + 32'd1));

  p_rx_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !reg_we) |=> $stable(rx_words));

  p_timeout_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_result == 3'd2 && !reg_we) |=> (rx_result == 3'd2));

  p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_result == 3'd3 && !reg_we) |=> (rx_result == 3'd3));

  p_result_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_result <= 3'd3));
endmodule

bind seqtest_top seqtest_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_cnt(tx_cnt_w), .rx_en(rx_en_w), .rx_words(rx_words_w),
  .rx_result(rx_result_w)
);

// File: tb/tb_seqtest_top.sv
`timescale 1ns/1ps
module tb_seqtest_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, rx_ready;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seqtest_top dut (.*);

  // {ctrl[1:0], start word, modulus}
  localparam logic [65:0] TXV [4] = '{
    {2'd3, 32'd5,          32'd9},
    {2'd3, 32'hFFFF_FFFD,  32'd0},
    {2'd1, 32'h0000_0001,  32'd0},
    {2'd1, 32'hDEAD_BEEF,  32'd0}
  };

  function automatic logic [31:0] m_prbs(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] m_cnt(logic [31:0] v, logic [31:0] m);
    logic [32:0] t;
    t = {1'b0, v} + 33'd1;
    if (m != 0 && t >= {1'b0, m}) t = 33'd0;
    return t[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = w;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd14, d); chk(d == 32'd1, "R1 status after reset", d, 32'd1);
    rd(4'd13, d); chk(d == 0, "R1 word count after reset", d, 0);
    rd(4'd3, d);  chk(d == 0, "R1 tx count after reset", d, 0);
    chk(tx_valid == 1'b0, "R2 tx idle after reset", {31'd0, tx_valid}, 0);
    chk(rx_ready == 1'b1, "R6 rx_ready high", {31'd0, rx_ready}, 1);

    // Table walk: R3 counter, R4 pseudo-random, R5 count
    for (int v = 0; v < 4; v++) begin
      tx_ready = 1'b0;
      wr(4'd0, TXV[v][63:32]);
      wr(4'd1, TXV[v][31:0]);
      wr(4'd2, {30'd0, TXV[v][65:64]});
      e = TXV[v][63:32];
      tx_ready = 1'b1;
      for (int i = 0; i < 12; i++) begin
        chk(tx_valid && tx_data == e, TXV[v][65] ? "R3 counter word" : "R4 prbs word", tx_data, e);
        e = TXV[v][65] ? m_cnt(e, TXV[v][31:0]) : m_prbs(e);
        @(negedge clk);
      end
      tx_ready = 1'b0;
      rd(4'd3, d); chk(d == 32'd12, "R5 tx count", d, 32'd12);
    end

    // R5 back-pressure
    wr(4'd0, 32'd100); wr(4'd1, 32'd0); wr(4'd2, 32'd3);
    repeat (3) @(negedge clk);
    chk(tx_data == 32'd100, "R5 hold under stall", tx_data, 32'd100);
    rd(4'd3, d); chk(d == 0, "R5 no count under stall", d, 0);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk(tx_data == 32'd101, "R5 advance after one transfer", tx_data, 32'd101);

    // R2 disabled encodings
    wr(4'd2, 32'd2); chk(tx_valid == 1'b0, "R2 ctrl 2 disabled", {31'd0, tx_valid}, 0);
    wr(4'd2, 32'd0); chk(tx_valid == 1'b0, "R2 ctrl 0 disabled", {31'd0, tx_valid}, 0);

    // R7 clean pseudo-random stream
    wr(4'd12, (32'd1000 << 8) | 32'd1);
    w = 32'h0000_1234;
    for (int i = 0; i < 6; i++) begin send(w); w = m_prbs(w); end
    rd(4'd13, d); chk(d == 6, "R7 word count", d, 6);
    rd(4'd14, d); chk(d == 32'd0, "R7 result ok no errors", d, 0);
    rd(4'd15, d); e = w; chk(d != e, "R9 last word not yet sent", d, e);
    // last sent word is predecessor of w; recompute
    e = 32'h0000_1234;
    for (int i = 0; i < 5; i++) e = m_prbs(e);
    chk(d == e, "R9 last word", d, e);

    // R9 one corrupt word counts two errors
    send(32'hBAD0_0BAD);
    send(w);
    send(m_prbs(w));
    rd(4'd14, d);
    chk(d[31:8] == 24'd2, "R9 error count", {8'd0, d[31:8]}, 32'd2);
    chk(d[2:0] == 3'd3, "R10 result error", {29'd0, d[2:0]}, 32'd3);

    // R8 counter with four steps, modulus 10
    wr(4'd1, 32'd10);
    wr(4'd8, 32'd1); wr(4'd9, 32'd4); wr(4'd10, 32'd7); wr(4'd11, 32'd0);
    wr(4'd12, (32'd1000 << 8) | 32'd3);
    rd(4'd14, d); chk(d == 32'd1, "R6 enable clears status", d, 32'd1);
    send(32'd3); send(32'd4); send(32'd8); send(32'd5); send(32'd5); send(32'd2);
    rd(4'd14, d); chk(d == 32'd0, "R8 all steps accepted", d, 0);
    send(32'd7);
    rd(4'd14, d);
    chk(d[31:8] == 24'd1, "R8 bad step counted", {8'd0, d[31:8]}, 32'd1);
    chk(d[2:0] == 3'd3, "R10 counter error result", {29'd0, d[2:0]}, 32'd3);
    send(32'd8);
    rd(4'd14, d); chk(d[2:0] == 3'd3, "R10 error sticky", {29'd0, d[2:0]}, 32'd3);

    // R6 disabled checker ignores input
    wr(4'd12, 32'd0);
    rd(4'd13, d); e = d;
    send(32'd1); send(32'd99); send(32'd42);
    rd(4'd13, d); chk(d == e, "R6 ignored word count", d, e);
    rd(4'd15, d); chk(d == 32'd8, "R6 ignored last word", d, 32'd8);

    // R11 timeout
    wr(4'd12, (32'd40 << 8) | 32'd1);
    repeat (20) @(negedge clk);
    rd(4'd14, d); chk(d == 32'd1, "R11 not yet timed out", d, 32'd1);
    repeat (30) @(negedge clk);
    rd(4'd14, d); chk(d == 32'd2, "R11 timeout", d, 32'd2);
    send(32'd3);
    rd(4'd14, d); chk(d[2:0] == 3'd2, "R11 timeout sticky", {29'd0, d[2:0]}, 32'd2);
    rd(4'd13, d); chk(d == 32'd1, "R11 word counted after timeout", d, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule